// File: doc/BRIEF.md
# Endpoint Handshake and Toggle Responder

This block chooses the handshake that one device endpoint returns to each host token and tracks the data-toggle PID for that endpoint. A token decoder in front of it delivers one-cycle strobes for IN, OUT, PING and SETUP tokens. It also delivers a valid-data strobe that carries the received data PID and the direction bit of the first setup byte. The bank controller beside it reports whether a bank is free to receive and whether a filled bank is ready to send.

Firmware has three ways to steer the block. It can arm a one-shot stall request, which the next SETUP cancels. It can reset the toggle. It can flush or disable the endpoint. The block reports several results: the handshake, whether the received OUT data is kept, the next expected PID and a toggle status field, plus sticky flags. The toggle status field shows the next PID for an IN endpoint and the PID of the current bank for an OUT or control endpoint. The sticky flags record NAKs sent to IN requests, NAKs sent to OUT/PING requests, a stall that has gone out, and a setup packet that has arrived. The block also captures the direction of the control transfer from each SETUP.

Top module: `ep_handshake_responder`

## Requirements
- R1: After reset the following hold. `hs_code` is 0. `tgl_next` and `tgl_status` are 1 (DATA1). All four sticky flags, `stall_pend`, `ctl_rd` and `keep_data` are 0.
- R2: `hs_code` encodes the handshake as 0 = none, 1 = ACK, 2 = NAK, 3 = STALL. It is registered, so it appears in the cycle after the deciding event and lasts one cycle unless another event follows.
- R3: `fw_stall` arms `stall_pend`. The next IN, PING or OUT data packet is answered with STALL, which sets `stall_sent_flag` and clears `stall_pend`. The token after that is not stalled.
- R4: A valid data packet after a SETUP token is always ACKed and has four effects. It clears `stall_pend`, sets `setup_flag`, loads `ctl_rd` from `setup_dir` (0 = control write), and sets `tgl_next` to DATA1. `fw_setup_clr` clears `setup_flag`.
- R5: IN with `bank_ready` low is answered NAK and sets `nak_in_flag`. IN with `bank_ready` high gives no handshake. PING or OUT data with `bank_free` low is answered NAK and sets `nak_out_flag`. PING with `bank_free` high is answered ACK.
- R6: When conditions coincide, STALL wins over NAK and NAK wins over ACK.
- R7: An OUT data packet whose PID equals `tgl_next` is ACKed, gives `keep_data` = 1 and flips `tgl_next` between 0 and 1. A packet with any other PID, including 2 or 3, is ACKed with `keep_data` = 0 and leaves `tgl_next` unchanged.
- R8: `in_acked` flips `tgl_next`. When `ep_is_in` is 1, `tgl_status` equals `tgl_next`.
- R9: When `ep_is_in` is 0, `tgl_status` shows the PID stored in the current read bank. Each kept packet fills banks in order 0..NBANK-1. `bank_release` advances the read bank, and the read bank wraps after NBANK-1.
- R10: `tgl_clear` or `ep_disable` forces `tgl_next` to DATA1.
- R11: `ep_flush` or `ep_disable` clears `nak_out_flag`, `stall_sent_flag`, `setup_flag` and `ctl_rd`, and returns every bank PID to DATA1. `ep_disable` also clears `stall_pend`. Neither of them changes `nak_in_flag`; only `fw_nak_in_clr` clears it.
- R12: A valid data strobe with no pending OUT or SETUP token is ignored and gives no handshake and no state change. Any later IN or PING token cancels a pending OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in | input | 1 | IN token strobe |
| tok_out | input | 1 | OUT token strobe |
| tok_ping | input | 1 | PING token strobe |
| tok_setup | input | 1 | SETUP token strobe |
| pkt_valid | input | 1 | Valid data packet strobe |
| pkt_pid | input | 2 | Data PID of the received packet |
| setup_dir | input | 1 | Direction bit of the first setup byte |
| bank_free | input | 1 | A bank can take OUT data |
| bank_ready | input | 1 | A bank holds IN data |
| in_acked | input | 1 | Host acknowledged IN data |
| bank_release | input | 1 | Firmware released the current OUT bank |
| fw_stall | input | 1 | Arm one-shot stall |
| fw_nak_in_clr | input | 1 | Clear NAK-in flag |
| fw_setup_clr | input | 1 | Clear setup flag |
| tgl_clear | input | 1 | Reset toggle to DATA1 |
| ep_flush | input | 1 | Endpoint reset strobe |
| ep_disable | input | 1 | Endpoint disable strobe |
| ep_is_in | input | 1 | Endpoint direction is IN |
| hs_code | output | 2 | Handshake to send |
| keep_data | output | 1 | Received OUT data is kept |
| tgl_next | output | 2 | Next expected/sent PID |
| tgl_status | output | 2 | Toggle status field |
| ctl_rd | output | 1 | Control transfer reads from device |
| stall_pend | output | 1 | Stall request armed |
| nak_in_flag | output | 1 | NAK sent to IN |
| nak_out_flag | output | 1 | NAK sent to OUT/PING |
| stall_sent_flag | output | 1 | STALL has gone out |
| setup_flag | output | 1 | SETUP received |

## Verification
The assertions take several things for granted about the inputs. At most one of the token strobes and the data strobe is high in a cycle. The flush, disable and firmware strobes never share a cycle with a token or data strobe. The assertions rely on these assumptions because a flush arriving together with a STALL could legally clear the flag the STALL sets. The bench drives each stimulus as a single-cycle pulse in its own cycle. It changes the bank availability levels only between events, so every assertion stays within that contract.

// File: rtl/ep_handshake_responder.sv
module ep_handshake_responder #(
  parameter int NBANK = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  input  logic       tok_out,
  input  logic       tok_ping,
  input  logic       tok_setup,
  input  logic       pkt_valid,
  input  logic [1:0] pkt_pid,
  input  logic       setup_dir,
  input  logic       bank_free,
  input  logic       bank_ready,
  input  logic       in_acked,
  input  logic       bank_release,
  input  logic       fw_stall,
  input  logic       fw_nak_in_clr,
  input  logic       fw_setup_clr,
  input  logic       tgl_clear,
  input  logic       ep_flush,
  input  logic       ep_disable,
  input  logic       ep_is_in,
  output logic [1:0] hs_code,
  output logic       keep_data,
  output logic [1:0] tgl_next,
  output logic [1:0] tgl_status,
  output logic       ctl_rd,
  output logic       stall_pend,
  output logic       nak_in_flag,
  output logic       nak_out_flag,
  output logic       stall_sent_flag,
  output logic       setup_flag
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [BW-1:0] LAST = BW'(NBANK - 1);
  localparam logic [1:0] HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3;
  localparam logic [1:0] DATA1 = 2'd1;
  localparam logic [1:0] P_IDLE = 2'd0, P_OUT = 2'd1, P_SETUP = 2'd2;

  logic [1:0] pend_q;
  logic [1:0] hs_d;
  logic       keep_d, stall_go, setup_go, set_nak_in, set_nak_out;
  logic [1:0] pid_bank [NBANK];
  logic [BW-1:0] wr_q, rd_q;
  logic       clr_ep;

  assign clr_ep = ep_flush | ep_disable;

  always_comb begin
    hs_d = HS_NONE;
    keep_d = 1'b0;
    stall_go = 1'b0;
    setup_go = 1'b0;
    set_nak_in = 1'b0;
    set_nak_out = 1'b0;
    if (tok_in) begin
      if (stall_pend) begin
        hs_d = HS_STALL; stall_go = 1'b1;
      end else if (!bank_ready) begin
        hs_d = HS_NAK; set_nak_in = 1'b1;
      end
    end else if (tok_ping) begin
      if (stall_pend) begin
        hs_d = HS_STALL; stall_go = 1'b1;
      end else if (!bank_free) begin
        hs_d = HS_NAK; set_nak_out = 1'b1;
      end else begin
        hs_d = HS_ACK;
      end
    end else if (pkt_valid && pend_q == P_SETUP) begin
      hs_d = HS_ACK; setup_go = 1'b1;
    end else if (pkt_valid && pend_q == P_OUT) begin
      if (stall_pend) begin
        hs_d = HS_STALL; stall_go = 1'b1;
      end else if (!bank_free) begin
        hs_d = HS_NAK; set_nak_out = 1'b1;
      end else begin
        hs_d = HS_ACK; keep_d = (pkt_pid == tgl_next);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ep)                  pend_q <= P_IDLE;
    else if (tok_out)                      pend_q <= P_OUT;
    else if (tok_setup)                    pend_q <= P_SETUP;
    else if (tok_in || tok_ping || pkt_valid) pend_q <= P_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_code <= HS_NONE;
      keep_data <= 1'b0;
    end else begin
      hs_code <= hs_d;
      keep_data <= keep_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ep_disable)      stall_pend <= 1'b0;
    else if (setup_go || stall_go) stall_pend <= 1'b0;
    else if (fw_stall)             stall_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ep) begin
      stall_sent_flag <= 1'b0;
      nak_out_flag <= 1'b0;
      setup_flag <= 1'b0;
      ctl_rd <= 1'b0;
    end else begin
      if (stall_go)         stall_sent_flag <= 1'b1;
      if (set_nak_out)      nak_out_flag <= 1'b1;
      if (setup_go)         setup_flag <= 1'b1;
      else if (fw_setup_clr) setup_flag <= 1'b0;
      if (setup_go)         ctl_rd <= setup_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             nak_in_flag <= 1'b0;
    else if (set_nak_in)    nak_in_flag <= 1'b1;
    else if (fw_nak_in_clr) nak_in_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ep_disable || tgl_clear || setup_go) tgl_next <= DATA1;
    else if (keep_d || in_acked) tgl_next <= {1'b0, ~tgl_next[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ep) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (keep_d)       wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (bank_release) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n || clr_ep)              pid_bank[b] <= DATA1;
      else if (keep_d && wr_q == BW'(b)) pid_bank[b] <= pkt_pid;
    end
  end

  assign tgl_status = ep_is_in ? tgl_next : pid_bank[rd_q];

  p_stall_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_STALL) |-> (stall_sent_flag && !stall_pend));
  p_setup_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_flag) |-> (hs_code == HS_ACK && !stall_pend && tgl_next == DATA1));
  p_nak_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_NAK) |-> (nak_in_flag || nak_out_flag));
  p_keep_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    keep_data |-> (hs_code == HS_ACK));
  p_tgl_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tgl_next[1]);
  p_dis_tgl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ep_disable |=> (tgl_next == DATA1 && !stall_pend));
  p_flush_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ep_flush |=> (!nak_out_flag && !stall_sent_flag && !setup_flag));
endmodule

// File: tb/tb_ep_handshake_responder.sv
`timescale 1ns/1ps
module tb_ep_handshake_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_in = 0, tok_out = 0, tok_ping = 0, tok_setup = 0, pkt_valid = 0;
  logic [1:0] pkt_pid = 0;
  logic setup_dir = 0, bank_free = 1, bank_ready = 1, in_acked = 0, bank_release = 0;
  logic fw_stall = 0, fw_nak_in_clr = 0, fw_setup_clr = 0, tgl_clear = 0;
  logic ep_flush = 0, ep_disable = 0, ep_is_in = 0;
  logic [1:0] hs_code, tgl_next, tgl_status;
  logic keep_data, ctl_rd, stall_pend, nak_in_flag, nak_out_flag, stall_sent_flag, setup_flag;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  ep_handshake_responder #(.NBANK(3)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tok_in = 0; tok_out = 0; tok_ping = 0; tok_setup = 0; pkt_valid = 0;
    in_acked = 0; bank_release = 0; fw_stall = 0; fw_nak_in_clr = 0;
    fw_setup_clr = 0; tgl_clear = 0; ep_flush = 0; ep_disable = 0;
  endtask

  task automatic out_pkt(logic [1:0] pid);
    tok_out = 1; step();
    pkt_valid = 1; pkt_pid = pid; step();
  endtask

  task automatic t_reset();
    chk("R1 hs", hs_code, 0);
    chk("R1 tgl_next", tgl_next, 1);
    chk("R1 tgl_status", tgl_status, 1);
    chk("R1 flags", {nak_in_flag, nak_out_flag, stall_sent_flag, setup_flag, stall_pend, ctl_rd, keep_data}, 0);
  endtask

  task automatic t_nak();
    bank_ready = 0; tok_in = 1; step();
    chk("R5 IN nak", hs_code, 2);
    chk("R5 nak_in", nak_in_flag, 1);
    step();
    chk("R2 one-cycle pulse", hs_code, 0);
    bank_free = 0; tok_ping = 1; step();
    chk("R5 PING nak", hs_code, 2);
    chk("R5 nak_out", nak_out_flag, 1);
    bank_free = 1; tok_ping = 1; step();
    chk("R5 PING ack", hs_code, 1);
    bank_ready = 1; tok_in = 1; step();
    chk("R5 IN ready none", hs_code, 0);
    ep_flush = 1; step();
    chk("R11 flush nak_out", nak_out_flag, 0);
    chk("R11 flush keeps nak_in", nak_in_flag, 1);
    fw_nak_in_clr = 1; step();
    chk("R11 fw clears nak_in", nak_in_flag, 0);
  endtask

  task automatic t_out_banks();
    ep_is_in = 0; bank_free = 1;
    out_pkt(2'd1);
    chk("R7 match ack", hs_code, 1);
    chk("R7 match keep", keep_data, 1);
    chk("R7 toggle flips", tgl_next, 0);
    chk("R9 bank0 pid", tgl_status, 1);
    out_pkt(2'd1);
    chk("R7 mismatch ack", hs_code, 1);
    chk("R7 mismatch discard", keep_data, 0);
    chk("R7 mismatch hold", tgl_next, 0);
    out_pkt(2'd2);
    chk("R7 reserved pid discard", keep_data, 0);
    out_pkt(2'd0);
    chk("R7 second keep", keep_data, 1);
    chk("R7 toggle back", tgl_next, 1);
    out_pkt(2'd1);
    chk("R9 status before wrap", tgl_status, 1);
    out_pkt(2'd0);
    chk("R7 fourth keep", keep_data, 1);
    bank_release = 1; step();
    chk("R9 bank1", tgl_status, 0);
    bank_release = 1; step();
    chk("R9 bank2", tgl_status, 1);
    bank_release = 1; step();
    chk("R9 wrap bank0", tgl_status, 0);
    bank_free = 0; out_pkt(2'd1);
    chk("R5 OUT nak", hs_code, 2);
    chk("R5 OUT nak keep", keep_data, 0);
    chk("R5 OUT nak_out", nak_out_flag, 1);
    bank_free = 1;
    ep_flush = 1; step();
    chk("R11 flush bank pid", tgl_status, 1);
    chk("R11 flush leaves toggle", tgl_next, 1);
  endtask

  task automatic t_stall();
    fw_stall = 1; step();
    chk("R3 armed", stall_pend, 1);
    bank_ready = 0; tok_in = 1; step();
    chk("R6 stall over nak", hs_code, 3);
    chk("R3 stall_sent", stall_sent_flag, 1);
    chk("R3 one-shot", stall_pend, 0);
    chk("R6 no nak_in", nak_in_flag, 0);
    tok_in = 1; step();
    chk("R3 next not stalled", hs_code, 2);
    fw_nak_in_clr = 1; step();
    bank_ready = 1;
    fw_stall = 1; step();
    bank_free = 0; out_pkt(2'd1);
    chk("R6 OUT stall over nak", hs_code, 3);
    chk("R6 OUT no nak_out", nak_out_flag, 0);
    bank_free = 1;
    fw_stall = 1; step();
    tok_ping = 1; step();
    chk("R3 PING stall", hs_code, 3);
  endtask

  task automatic t_setup();
    in_acked = 1; step();
    chk("R8 toggle before setup", tgl_next, 0);
    fw_stall = 1; step();
    tok_setup = 1; step();
    pkt_valid = 1; setup_dir = 1; step();
    chk("R4 setup ack", hs_code, 1);
    chk("R4 flag", setup_flag, 1);
    chk("R4 dir read", ctl_rd, 1);
    chk("R4 cancels stall", stall_pend, 0);
    chk("R4 toggle DATA1", tgl_next, 1);
    tok_in = 1; bank_ready = 1; step();
    chk("R4 IN not stalled", hs_code, 0);
    fw_setup_clr = 1; step();
    chk("R4 fw clear", setup_flag, 0);
    tok_setup = 1; step();
    pkt_valid = 1; setup_dir = 0; step();
    chk("R4 dir write", ctl_rd, 0);
  endtask

  task automatic t_in_toggle();
    ep_is_in = 1;
    chk("R8 status follows", tgl_status, tgl_next);
    in_acked = 1; step();
    chk("R8 flip", tgl_next, 0);
    chk("R8 status IN", tgl_status, 0);
    in_acked = 1; step();
    chk("R8 flip back", tgl_next, 1);
    in_acked = 1; step();
    tgl_clear = 1; step();
    chk("R10 toggle clear", tgl_next, 1);
    in_acked = 1; step();
    fw_stall = 1; step();
    tok_setup = 1; step();
    pkt_valid = 1; setup_dir = 1; step();
    bank_free = 0; tok_ping = 1; step();
    fw_stall = 1; step();
    in_acked = 1; step();
    ep_disable = 1; step();
    chk("R10 disable toggle", tgl_next, 1);
    chk("R11 disable flags", {nak_out_flag, stall_sent_flag, setup_flag, ctl_rd, stall_pend}, 0);
    bank_free = 1;
    ep_is_in = 0;
  endtask

  task automatic t_orphan();
    pkt_valid = 1; pkt_pid = 1; step();
    chk("R12 lone pkt hs", hs_code, 0);
    chk("R12 lone pkt keep", keep_data, 0);
    chk("R12 lone pkt toggle", tgl_next, 1);
    tok_out = 1; step();
    tok_ping = 1; step();
    pkt_valid = 1; pkt_pid = 1; step();
    chk("R12 cancelled out", hs_code, 0);
    chk("R12 cancelled toggle", tgl_next, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nak();
    t_out_banks();
    t_stall();
    t_setup();
    t_in_toggle();
    t_orphan();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule